// File: doc/BRIEF.md
# Tagless Two-Hash Log Mapping Table

This block maps a request address to candidate log slots in a compressed cache. Each of its entries stores a small log pointer and a coherence state, and no address tag. Because no tag is stored, a valid entry only names a log that *may* hold the line. A tag check outside this block confirms the line, or reports an aliased miss when the log does not hold the address.

Every address has two possible entries, picked by two different hash functions in the manner of a column-associative cache. A lookup reads both entries, one per cycle, and returns the valid flag, pointer and state of each. When both candidates are invalid, the block reports a miss at once, so the caller can skip tag decompression.

After the external tag check, the caller sends an update for a write or a refill. The update names the candidate that matched, and the block rewrites that entry with the log just written and the new state.

Top module: `tagless_map_table`

## Requirements
- R1: After reset every entry is Invalid (state code 0). `lk_ready` is 1 and `lk_done` is 0.
- R2: Candidate 0 is the entry at index `addr[5:0]`. Candidate 1 is the entry at index `addr[5:0] ^ addr[11:6]`. For each candidate the block returns the stored 4-bit pointer and 2-bit state, and the valid flag is 1 when the state is not Invalid. The state codes are I=0, S=1, E=2, M=3.
- R3: A lookup is accepted on a rising edge where `lk_req` and `lk_ready` are both 1.
  - `lk_ready` is 0 in the cycle that follows the accept.
  - `lk_done` is 1 for exactly one cycle, in the second cycle after the accept.
  - Candidate 0 reflects the table as it was at the accepting edge. Candidate 1 reflects the table as it was one edge later.
- R4: `lk_fast_miss` is 1 while `lk_done` is 1 and both candidates are invalid, and is 0 otherwise.
- R5: A `lk_req` while `lk_ready` is 0 is ignored. It leaves the candidate outputs unchanged and causes no extra `lk_done` pulse.
- R6: An update with `upd_write`=1 stores `upd_ptr` into the target entry with state M (3).
- R7: An update with `upd_write`=0 (refill) stores `upd_ptr` into the target entry. The state is S (1) when `upd_shared`=1 and E (2) otherwise, and never M.
- R8: The target entry of an update depends on `upd_match`:
  - when bit 0 is set, the candidate 0 index of `upd_addr`;
  - when only bit 1 is set, the candidate 1 index;
  - when neither bit is set, the candidate 0 index.
- R9: The valid flag does not depend on the address that filled an entry. Any other address that hashes to a filled entry sees it as a valid candidate.
- R10: The candidate outputs keep their values until the next accepted lookup loads new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 16 | Lookup address |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_done | output | 1 | Candidate results are valid this cycle |
| lk_fast_miss | output | 1 | Both candidates invalid |
| cand0_valid | output | 1 | Candidate 0 entry in use |
| cand0_ptr | output | 4 | Candidate 0 log pointer |
| cand0_state | output | 2 | Candidate 0 coherence state |
| cand1_valid | output | 1 | Candidate 1 entry in use |
| cand1_ptr | output | 4 | Candidate 1 log pointer |
| cand1_state | output | 2 | Candidate 1 coherence state |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_addr | input | 16 | Address of the line written or refilled |
| upd_match | input | 2 | Candidate that passed the external tag check |
| upd_write | input | 1 | 1 = write (state M), 0 = refill |
| upd_shared | input | 1 | Refill state: 1 = Shared, 0 = Exclusive |
| upd_ptr | input | 4 | Log slot just written |

## Verification
The assertions assume several things about the inputs:
- `rst_n` is synchronous and is held for at least one edge.
- Any update may coincide with any lookup phase. When it does, the entry read in that phase shows the value from before the update.
- `upd_match` is an arbitrary two-bit value, and the value 3 resolves to candidate 0.

The stimulus drives every input half a clock away from the sampling edge. It deliberately overlaps updates with both lookup phases. It also uses addresses whose two hashes coincide, and it issues requests while the block is busy. This exercises the orderings that the bench's reference model must reproduce.

// File: rtl/tagless_map_table.sv
module tagless_map_table #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              lk_done,
  output logic              lk_fast_miss,
  output logic              cand0_valid,
  output logic [PTR_W-1:0]  cand0_ptr,
  output logic [1:0]        cand0_state,
  output logic              cand1_valid,
  output logic [PTR_W-1:0]  cand1_ptr,
  output logic [1:0]        cand1_state,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [1:0]        upd_match,
  input  logic              upd_write,
  input  logic              upd_shared,
  input  logic [PTR_W-1:0]  upd_ptr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;

  logic [1:0]        st_q  [DEPTH];
  logic [PTR_W-1:0]  ptr_q [DEPTH];
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  lk_h0, pend_h1, upd_h0, upd_h1, upd_idx;
  logic [1:0]        upd_state;
  logic              accept;

  function automatic logic [IDX_W-1:0] hash0(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] hash1(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
  endfunction

  assign accept    = lk_req && !busy_q;
  assign lk_ready  = !busy_q;
  assign lk_h0     = hash0(lk_addr);
  assign pend_h1   = hash1(addr_q);
  assign upd_h0    = hash0(upd_addr);
  assign upd_h1    = hash1(upd_addr);
  assign upd_idx   = (upd_match == 2'b10) ? upd_h1 : upd_h0;
  assign upd_state = upd_write ? ST_M : (upd_shared ? ST_S : ST_E);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= ST_I;
        ptr_q[i] <= '0;
      end
    end else if (upd_valid) begin
      st_q[upd_idx]  <= upd_state;
      ptr_q[upd_idx] <= upd_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      lk_done     <= 1'b0;
      addr_q      <= '0;
      cand0_ptr   <= '0;
      cand0_state <= ST_I;
      cand1_ptr   <= '0;
      cand1_state <= ST_I;
    end else begin
      busy_q  <= accept;
      lk_done <= busy_q;
      if (accept) begin
        addr_q      <= lk_addr;
        cand0_ptr   <= ptr_q[lk_h0];
        cand0_state <= st_q[lk_h0];
      end
      if (busy_q) begin
        cand1_ptr   <= ptr_q[pend_h1];
        cand1_state <= st_q[pend_h1];
      end
    end
  end

  assign cand0_valid  = cand0_state != ST_I;
  assign cand1_valid  = cand1_state != ST_I;
  assign lk_fast_miss = lk_done && !cand0_valid && !cand1_valid;

  // R3
  busy_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |=> (lk_done && lk_ready));

  // R6
  write_sets_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_write) |=> (st_q[$past(upd_idx)] == ST_M && ptr_q[$past(upd_idx)] == $past(upd_ptr)));

  // R7
  refill_not_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_write) |=> (st_q[$past(upd_idx)] != ST_M && st_q[$past(upd_idx)] != ST_I));

  // R10
  cand1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |=> ($stable(cand1_ptr) && $stable(cand1_state)));

  // R4
  fast_miss_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fast_miss |-> $past(!lk_ready));
endmodule

// File: tb/tagless_map_table_test.sv
module tagless_map_table_test;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0, upd_valid = 0, upd_write = 0, upd_shared = 0;
  logic [15:0] lk_addr = 0, upd_addr = 0;
  logic [1:0] upd_match = 0;
  logic [3:0] upd_ptr = 0;
  logic lk_ready, lk_done, lk_fast_miss, cand0_valid, cand1_valid;
  logic [3:0] cand0_ptr, cand1_ptr;
  logic [1:0] cand0_state, cand1_state;

  always #5 clk = ~clk;

  tagless_map_table uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_ready(lk_ready), .lk_done(lk_done), .lk_fast_miss(lk_fast_miss),
    .cand0_valid(cand0_valid), .cand0_ptr(cand0_ptr), .cand0_state(cand0_state),
    .cand1_valid(cand1_valid), .cand1_ptr(cand1_ptr), .cand1_state(cand1_state),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_match(upd_match),
    .upd_write(upd_write), .upd_shared(upd_shared), .upd_ptr(upd_ptr));

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";

  int m_st[64], m_ptr[64];
  int m_busy = 0, m_done = 0, m_addr = 0;
  int m_c0p = 0, m_c0s = 0, m_c1p = 0, m_c1s = 0;

  always @(posedge clk) begin
    int o_st[64], o_ptr[64];
    int ob;
    int ti, st;
    if (!rst_n) begin
      foreach (m_st[i]) begin m_st[i] = 0; m_ptr[i] = 0; end
      m_busy = 0; m_done = 0; m_addr = 0;
      m_c0p = 0; m_c0s = 0; m_c1p = 0; m_c1s = 0;
    end else begin
      o_st = m_st; o_ptr = m_ptr; ob = m_busy;
      m_done = ob;
      if (ob != 0) begin
        ti = (m_addr % 64) ^ ((m_addr / 64) % 64);
        m_c1p = o_ptr[ti]; m_c1s = o_st[ti];
      end
      m_busy = (lk_req && ob == 0) ? 1 : 0;
      if (lk_req && ob == 0) begin
        m_addr = int'(lk_addr);
        m_c0p = o_ptr[lk_addr % 64]; m_c0s = o_st[lk_addr % 64];
      end
      if (upd_valid) begin
        if (upd_match == 2'b10) ti = (upd_addr % 64) ^ ((upd_addr / 64) % 64);
        else ti = upd_addr % 64;
        st = upd_write ? 3 : (upd_shared ? 1 : 2);
        m_st[ti] = st; m_ptr[ti] = int'(upd_ptr);
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("ready", int'(lk_ready), m_busy == 0 ? 1 : 0);
    cmp("done", int'(lk_done), m_done);
    cmp("fast_miss", int'(lk_fast_miss), (m_done != 0 && m_c0s == 0 && m_c1s == 0) ? 1 : 0);
    cmp("c0_state", int'(cand0_state), m_c0s);
    cmp("c0_ptr", int'(cand0_ptr), m_c0p);
    cmp("c0_valid", int'(cand0_valid), m_c0s != 0 ? 1 : 0);
    cmp("c1_state", int'(cand1_state), m_c1s);
    cmp("c1_ptr", int'(cand1_ptr), m_c1p);
    cmp("c1_valid", int'(cand1_valid), m_c1s != 0 ? 1 : 0);
  end

  task automatic step();
    @(negedge clk); #1;
    lk_req = 0; upd_valid = 0;
  endtask

  task automatic lookup(input logic [15:0] a);
    @(negedge clk); #1;
    lk_req = 1; lk_addr = a; upd_valid = 0;
    step(); step(); step();
  endtask

  task automatic update(input logic [15:0] a, input logic [1:0] m, input logic w,
                        input logic sh, input logic [3:0] p);
    @(negedge clk); #1;
    lk_req = 0; upd_valid = 1; upd_addr = a; upd_match = m;
    upd_write = w; upd_shared = sh; upd_ptr = p;
    step();
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    phase = "R1"; step();
    lookup(16'h0000); lookup(16'h0abc);
    phase = "R4"; lookup(16'h0123);
    phase = "R6"; update(16'h0005, 2'b00, 1, 0, 4'd9); lookup(16'h0005);
    phase = "R7"; update(16'h0007, 2'b01, 0, 1, 4'd3); update(16'h0008, 2'b00, 0, 0, 4'd4);
    lookup(16'h0007); lookup(16'h0008);
    phase = "R8"; update(16'h0241, 2'b10, 1, 0, 4'd12);
    lookup(16'h0241); lookup(16'h0240 ^ 16'h0008);
    update(16'h0310, 2'b11, 0, 0, 4'd6); lookup(16'h0310);
    phase = "R2"; lookup(16'h0fc5); lookup(16'h0050);
    phase = "R9"; lookup(16'h3045); lookup(16'hf007);
    phase = "R5";
    @(negedge clk); #1 lk_req = 1; lk_addr = 16'h0005;
    @(negedge clk); #1 lk_addr = 16'h0008;
    @(negedge clk); #1 lk_addr = 16'h0007; lk_req = 0;
    step(); step();
    phase = "R10"; step(); step(); step();
    phase = "R3";
    @(negedge clk); #1 lk_req = 1; lk_addr = 16'h0241;
    upd_valid = 1; upd_addr = 16'h0001; upd_match = 0; upd_write = 0; upd_shared = 1; upd_ptr = 4'd2;
    @(negedge clk); #1 upd_addr = 16'h0241; upd_match = 2'b10; upd_write = 1; upd_ptr = 4'd15;
    step(); step(); step();
    lf = 16'hace1;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lk_req = lf[0]; lk_addr = {lf[3:0], lf[15:4]};
      upd_valid = lf[5] & lf[9]; upd_addr = {lf[7:0], lf[15:8]};
      upd_match = lf[11:10]; upd_write = lf[12]; upd_shared = lf[13]; upd_ptr = lf[15:12];
    end
    step(); step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule